// File: doc/BRIEF.md
# Video Frame Packet Sequencer

This block walks through a video frame line by line and issues, one at a time, the packet requests a serial display link needs in video mode. A frame is made of vertical back porch lines, then active lines, then vertical front porch lines. After the last front porch line the frame starts again. Each line opens with a sync region and is followed by horizontal blanking, pixel and filler (BLLP) regions. The order of these regions depends on the selected video mode.

Every request is either a packet (a 6-bit data type plus a 16-bit payload byte count) or a low-power interval. A downstream packet engine takes the request through a valid/acknowledge handshake: a request is consumed on a rising clock edge where both `reqValid` and `reqAck` are high. The configuration inputs are expected to stay static while the block runs, and are changed only under reset.

Top module: `frame_pkt_seq`

## Requirements
- R1: While `rstN` is low, `reqValid` is 0. After reset the first request is a vertical sync start (data type 0x01, count 0, `reqLowPower` 0).
- R2: The first line of every frame opens with vertical sync start 0x01 and, in mode 0, closes its sync region with vertical sync end 0x11. Every other line uses horizontal sync start 0x21 and horizontal sync end 0x31. All sync packets carry a count of 0.
- R3: In mode 0 (non-burst, sync pulses) the sync region of each line is: start packet, then a blanking packet (data type 0x19) of `hsaBytes`, then the end packet.
- R4: In mode 1 (non-burst, sync events) and in modes 2 and 3 (burst), the sync region is the start packet alone.
- R5: In modes 0 and 1, an active line continues after its sync region with a blanking packet 0x19 of `hbpBytes`, then a pixel packet of type `pixelDataType` and count `pixelBytes`, then a blanking packet 0x19 of `hfpBytes`.
- R6: In modes 2 and 3, an active line continues with the `hbpBytes` blanking packet and the pixel packet, then one BLLP request in place of the front porch packet.
- R7: A back porch or front porch line consists of its sync region followed by exactly one BLLP request.
- R8: A BLLP request has one of three forms. With `bllpLowPower` = 1 it is a low-power interval (`reqLowPower` 1, data type 0, count 0). Otherwise it is a packet of `bllpBytes`, with data type 0x09 (null) if `bllpUseNull` = 1 and 0x19 (blanking) if it is 0.
- R9: A frame has `vbpLines` back porch lines, then `vactLines` active lines, then `vfpLines` front porch lines, and frames repeat without a gap. A region with a count of zero is skipped. If all three counts are zero, each frame is a single porch line.
- R10: While `reqValid` is 1 and `reqAck` is 0, the request fields hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidMode | input | 2 | 0 sync pulses, 1 sync events, 2 or 3 burst |
| vbpLines | input | 8 | Vertical back porch line count |
| vactLines | input | 14 | Vertical active line count |
| vfpLines | input | 8 | Vertical front porch line count |
| hsaBytes | input | 16 | Sync-width blanking payload bytes |
| hbpBytes | input | 16 | Horizontal back porch payload bytes |
| hfpBytes | input | 16 | Horizontal front porch payload bytes |
| bllpBytes | input | 16 | Filler packet payload bytes |
| pixelBytes | input | 16 | Pixel packet payload bytes per line |
| pixelDataType | input | 6 | Data type used for pixel packets |
| bllpLowPower | input | 1 | Spend BLLP periods in low power |
| bllpUseNull | input | 1 | Fill BLLP with null rather than blanking packets |
| reqAck | input | 1 | Downstream accepts the current request |
| reqValid | output | 1 | A request is presented |
| reqDataType | output | 6 | Packet data type |
| reqByteCount | output | 16 | Packet payload byte count |
| reqLowPower | output | 1 | Request is a low-power interval |

## Verification
Directed frames in each of the three mode families are compared against a request list the bench builds from the region counts. These runs separate sync-pulse line shapes from sync-event line shapes, and non-burst line endings from burst line endings. One run per filler setting (low-power, null, blanking) shows that the BLLP choice is made independently of the mode. Frames with a zero back porch, and frames with all counts zero, show where the vertical sync moves and how region skipping works. Random region counts, modes and payload sizes, under random acknowledge stalls, check that frame wrapping is right and that requests hold steady while a stall lasts.

// File: rtl/frame_pkt_seq_pkg.sv
package frame_pkt_seq_pkg;

  localparam int DT_W = 6;

  localparam logic [DT_W-1:0] DT_VSYNC_START = 6'h01;
  localparam logic [DT_W-1:0] DT_VSYNC_END   = 6'h11;
  localparam logic [DT_W-1:0] DT_HSYNC_START = 6'h21;
  localparam logic [DT_W-1:0] DT_HSYNC_END   = 6'h31;
  localparam logic [DT_W-1:0] DT_BLANK       = 6'h19;
  localparam logic [DT_W-1:0] DT_NULL        = 6'h09;

  typedef enum logic [2:0] {
    STEP_START = 3'd0,
    STEP_HSA   = 3'd1,
    STEP_END   = 3'd2,
    STEP_HBP   = 3'd3,
    STEP_PIX   = 3'd4,
    STEP_TAIL  = 3'd5
  } seqStep_t;

  typedef struct packed {
    seqStep_t step;
    logic     lineDone;
  } seqCtl_t;

endpackage

// File: rtl/frame_pkt_seq_ctrl.sv
module frame_pkt_seq_ctrl
  import frame_pkt_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] vidMode,
  input  logic       isActive,
  input  logic       reqAck,
  output logic       reqValid,
  output seqCtl_t    ctl
);

  seqStep_t step, stepNext;
  logic running;
  logic advance;
  logic pulseMode;

  assign pulseMode = (vidMode == 2'd0);
  assign advance   = running && reqAck;
  assign reqValid  = running;

  always_comb begin
    stepNext = step;
    unique case (step)
      STEP_START: stepNext = pulseMode ? STEP_HSA : (isActive ? STEP_HBP : STEP_TAIL);
      STEP_HSA:   stepNext = STEP_END;
      STEP_END:   stepNext = isActive ? STEP_HBP : STEP_TAIL;
      STEP_HBP:   stepNext = STEP_PIX;
      STEP_PIX:   stepNext = STEP_TAIL;
      STEP_TAIL:  stepNext = STEP_START;
      default:    stepNext = STEP_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      step    <= STEP_START;
    end else begin
      running <= 1'b1;
      if (advance) step <= stepNext;
    end
  end

  always_comb begin
    ctl.step     = step;
    ctl.lineDone = advance && (step == STEP_TAIL);
  end

  // R3: accepted sync-width packet is always followed by the sync end step
  assert_pulse_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAck && step == STEP_HSA) |=> (step == STEP_END));

  // R4: outside sync-pulse mode no sync-width or sync-end step is presented
  assert_event_start_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vidMode != 2'd0) |-> !(step == STEP_HSA || step == STEP_END));

endmodule

// File: rtl/frame_pkt_seq_dp.sv
module frame_pkt_seq_dp
  import frame_pkt_seq_pkg::*;
#(
  parameter int VPORCH_W = 8,
  parameter int VACT_W   = 14,
  parameter int BYTES_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic [1:0]          vidMode,
  input  logic [VPORCH_W-1:0] vbpLines,
  input  logic [VACT_W-1:0]   vactLines,
  input  logic [VPORCH_W-1:0] vfpLines,
  input  logic [BYTES_W-1:0]  hsaBytes,
  input  logic [BYTES_W-1:0]  hbpBytes,
  input  logic [BYTES_W-1:0]  hfpBytes,
  input  logic [BYTES_W-1:0]  bllpBytes,
  input  logic [BYTES_W-1:0]  pixelBytes,
  input  logic [DT_W-1:0]     pixelDataType,
  input  logic                bllpLowPower,
  input  logic                bllpUseNull,
  output logic                isActive,
  output logic [DT_W-1:0]     reqDataType,
  output logic [BYTES_W-1:0]  reqByteCount,
  output logic                reqLowPower
);

  localparam int LINE_W = ((VACT_W > VPORCH_W) ? VACT_W : VPORCH_W) + 2;

  logic [LINE_W-1:0] lineIdx;
  logic [LINE_W-1:0] vbpExt, activeEnd, frameLines;
  logic firstLine, lastLine, burstMode;

  assign vbpExt     = LINE_W'(vbpLines);
  assign activeEnd  = vbpExt + LINE_W'(vactLines);
  assign frameLines = activeEnd + LINE_W'(vfpLines);
  assign firstLine  = (lineIdx == '0);
  assign lastLine   = ((lineIdx + LINE_W'(1)) >= frameLines);
  assign isActive   = (lineIdx >= vbpExt) && (lineIdx < activeEnd);
  assign burstMode  = vidMode[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineIdx <= '0;
    end else if (ctl.lineDone) begin
      lineIdx <= lastLine ? '0 : lineIdx + LINE_W'(1);
    end
  end

  always_comb begin
    reqDataType  = '0;
    reqByteCount = '0;
    reqLowPower  = 1'b0;
    unique case (ctl.step)
      STEP_START: reqDataType = firstLine ? DT_VSYNC_START : DT_HSYNC_START;
      STEP_END:   reqDataType = firstLine ? DT_VSYNC_END : DT_HSYNC_END;
      STEP_HSA: begin
        reqDataType  = DT_BLANK;
        reqByteCount = hsaBytes;
      end
      STEP_HBP: begin
        reqDataType  = DT_BLANK;
        reqByteCount = hbpBytes;
      end
      STEP_PIX: begin
        reqDataType  = pixelDataType;
        reqByteCount = pixelBytes;
      end
      STEP_TAIL: begin
        if (isActive && !burstMode) begin
          reqDataType  = DT_BLANK;
          reqByteCount = hfpBytes;
        end else if (bllpLowPower) begin
          reqLowPower = 1'b1;
        end else begin
          reqDataType  = bllpUseNull ? DT_NULL : DT_BLANK;
          reqByteCount = bllpBytes;
        end
      end
      default: ;
    endcase
  end

  // R5: a pixel request only ever appears on an active line
  assert_pixel_on_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step == STEP_PIX) |-> isActive);

  // R8: a low-power interval is only requested in the closing step of a line
  assert_lp_in_tail_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqLowPower |-> (ctl.step == STEP_TAIL && bllpLowPower));

endmodule

// File: rtl/frame_pkt_seq.sv
module frame_pkt_seq
  import frame_pkt_seq_pkg::*;
#(
  parameter int VPORCH_W = 8,
  parameter int VACT_W   = 14,
  parameter int BYTES_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          vidMode,
  input  logic [VPORCH_W-1:0] vbpLines,
  input  logic [VACT_W-1:0]   vactLines,
  input  logic [VPORCH_W-1:0] vfpLines,
  input  logic [BYTES_W-1:0]  hsaBytes,
  input  logic [BYTES_W-1:0]  hbpBytes,
  input  logic [BYTES_W-1:0]  hfpBytes,
  input  logic [BYTES_W-1:0]  bllpBytes,
  input  logic [BYTES_W-1:0]  pixelBytes,
  input  logic [5:0]          pixelDataType,
  input  logic                bllpLowPower,
  input  logic                bllpUseNull,
  input  logic                reqAck,
  output logic                reqValid,
  output logic [5:0]          reqDataType,
  output logic [BYTES_W-1:0]  reqByteCount,
  output logic                reqLowPower
);

  seqCtl_t ctl;
  logic isActive;

  frame_pkt_seq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .vidMode  (vidMode),
    .isActive (isActive),
    .reqAck   (reqAck),
    .reqValid (reqValid),
    .ctl      (ctl)
  );

  frame_pkt_seq_dp #(
    .VPORCH_W (VPORCH_W),
    .VACT_W   (VACT_W),
    .BYTES_W  (BYTES_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .vidMode       (vidMode),
    .vbpLines      (vbpLines),
    .vactLines     (vactLines),
    .vfpLines      (vfpLines),
    .hsaBytes      (hsaBytes),
    .hbpBytes      (hbpBytes),
    .hfpBytes      (hfpBytes),
    .bllpBytes     (bllpBytes),
    .pixelBytes    (pixelBytes),
    .pixelDataType (pixelDataType),
    .bllpLowPower  (bllpLowPower),
    .bllpUseNull   (bllpUseNull),
    .isActive      (isActive),
    .reqDataType   (reqDataType),
    .reqByteCount  (reqByteCount),
    .reqLowPower   (reqLowPower)
  );

  // R10: a stalled request keeps all of its fields
  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqAck) |=> (reqValid && $stable(reqDataType)
                               && $stable(reqByteCount) && $stable(reqLowPower)));

  // R1: the first request presented after reset is a vertical sync start
  assert_first_vsync_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> (reqDataType == DT_VSYNC_START && reqByteCount == '0 && !reqLowPower));

endmodule

// File: tb/frame_pkt_seq_test.sv
`timescale 1ns/1ps
module frame_pkt_seq_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic [1:0]  vidMode = '0;
  logic [7:0]  vbpLines = '0;
  logic [13:0] vactLines = '0;
  logic [7:0]  vfpLines = '0;
  logic [15:0] hsaBytes = '0, hbpBytes = '0, hfpBytes = '0, bllpBytes = '0, pixelBytes = '0;
  logic [5:0]  pixelDataType = 6'h3E;
  logic        bllpLowPower = 1'b0, bllpUseNull = 1'b0;
  logic        reqAck = 1'b0;
  logic        reqValid;
  logic [5:0]  reqDataType;
  logic [15:0] reqByteCount;
  logic        reqLowPower;

  frame_pkt_seq uut (
    .clk(clk), .rstN(rstN), .vidMode(vidMode), .vbpLines(vbpLines),
    .vactLines(vactLines), .vfpLines(vfpLines), .hsaBytes(hsaBytes),
    .hbpBytes(hbpBytes), .hfpBytes(hfpBytes), .bllpBytes(bllpBytes),
    .pixelBytes(pixelBytes), .pixelDataType(pixelDataType),
    .bllpLowPower(bllpLowPower), .bllpUseNull(bllpUseNull), .reqAck(reqAck),
    .reqValid(reqValid), .reqDataType(reqDataType), .reqByteCount(reqByteCount),
    .reqLowPower(reqLowPower)
  );

  int checks = 0;
  int failures = 0;
  logic [22:0] expQ[$];
  string       tagQ[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual lp=%0d dt=0x%02h n=%0d expected lp=%0d dt=0x%02h n=%0d",
               tag, what, act[22], act[21:16], act[15:0], exp[22], exp[21:16], exp[15:0]);
    end
  endtask

  task automatic pushReq(input bit lp, input logic [5:0] dt, input logic [15:0] n, input string tag);
    expQ.push_back({lp, dt, n});
    tagQ.push_back(tag);
  endtask

  function automatic logic [22:0] bllpItem();
    if (bllpLowPower) return {1'b1, 6'h00, 16'h0000};
    return {1'b0, (bllpUseNull ? 6'h09 : 6'h19), bllpBytes};
  endfunction

  // Expected request list, built from the requirements for whole frames
  task automatic buildFrames(input int nFrames);
    int total = int'(vbpLines) + int'(vactLines) + int'(vfpLines);
    if (total == 0) total = 1;
    for (int f = 0; f < nFrames; f++) begin
      for (int l = 0; l < total; l++) begin
        bit first = (l == 0);
        bit act = (l >= int'(vbpLines)) && (l < int'(vbpLines) + int'(vactLines));
        pushReq(1'b0, first ? 6'h01 : 6'h21, 16'h0, (f == 0 && first) ? "R1" : "R2");
        if (vidMode == 2'd0) begin
          pushReq(1'b0, 6'h19, hsaBytes, "R3");
          pushReq(1'b0, first ? 6'h11 : 6'h31, 16'h0, "R2");
        end
        if (act) begin
          pushReq(1'b0, 6'h19, hbpBytes, "R5");
          pushReq(1'b0, pixelDataType, pixelBytes, "R5");
          if (vidMode[1]) begin
            expQ.push_back(bllpItem()); tagQ.push_back("R6");
          end else begin
            pushReq(1'b0, 6'h19, hfpBytes, "R5");
          end
        end else begin
          expQ.push_back(bllpItem()); tagQ.push_back((vidMode == 2'd0) ? "R7" : "R4");
        end
      end
    end
  endtask

  task automatic runScenario(input int nFrames, input int stallPct, input string name);
    logic [22:0] cur, held, exp;
    bit holdPending = 1'b0;
    int guard = 0;
    rstN = 1'b0;
    reqAck = 1'b0;
    repeat (3) @(negedge clk);
    check(reqValid == 1'b0, "R1", {name, " valid low in reset"}, {22'h0, reqValid}, 23'h0);
    buildFrames(nFrames);
    rstN = 1'b1;
    while (expQ.size() > 0 && guard < 5000) begin
      bit ack;
      @(negedge clk);
      guard++;
      cur = {reqLowPower, reqDataType, reqByteCount};
      if (holdPending) check(cur == held, "R10", {name, " hold on stall"}, cur, held);
      ack = (($urandom % 100) >= stallPct);
      reqAck = ack;
      holdPending = 1'b0;
      if (reqValid && ack) begin
        string tag;
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        check(cur == exp, tag, name, cur, exp);
      end else if (reqValid) begin
        holdPending = 1'b1;
        held = cur;
      end
    end
    if (expQ.size() > 0) begin
      checks++;
      failures++;
      $display("FAIL R9 %s watchdog: actual remaining=%0d expected remaining=0", name, expQ.size());
      expQ.delete();
      tagQ.delete();
    end
    @(negedge clk);
    reqAck = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    hsaBytes = 16'd10; hbpBytes = 16'd20; hfpBytes = 16'd30;
    bllpBytes = 16'd40; pixelBytes = 16'd1920;

    // Sync pulses, blanking filler (R2 R3 R5 R7 R8 R9)
    vidMode = 2'd0; vbpLines = 8'd2; vactLines = 14'd3; vfpLines = 8'd2;
    bllpLowPower = 1'b0; bllpUseNull = 1'b0;
    runScenario(2, 0, "pulse-blank");
    runScenario(2, 50, "pulse-blank-stall");

    // Sync events, low-power filler (R4 R8)
    vidMode = 2'd1; bllpLowPower = 1'b1;
    runScenario(2, 30, "event-lp");

    // Burst, null filler (R6 R8)
    vidMode = 2'd2; bllpLowPower = 1'b0; bllpUseNull = 1'b1;
    runScenario(2, 30, "burst-null");

    // Burst code 3, low power (R6)
    vidMode = 2'd3; bllpLowPower = 1'b1;
    runScenario(1, 20, "burst3-lp");

    // No back porch: first active line carries vsync (R2 R9)
    vidMode = 2'd0; bllpLowPower = 1'b0; bllpUseNull = 1'b0;
    vbpLines = 8'd0; vactLines = 14'd2; vfpLines = 8'd0;
    runScenario(3, 25, "no-porch");

    // All counts zero: single porch line per frame (R9)
    vidMode = 2'd1; vactLines = 14'd0;
    runScenario(3, 25, "empty-frame");

    // Random configurations (R9 R10)
    for (int i = 0; i < 8; i++) begin
      vidMode = 2'($urandom % 4);
      vbpLines = 8'($urandom % 4);
      vactLines = 14'($urandom % 4);
      vfpLines = 8'($urandom % 4);
      hsaBytes = 16'($urandom); hbpBytes = 16'($urandom); hfpBytes = 16'($urandom);
      bllpBytes = 16'($urandom); pixelBytes = 16'($urandom);
      pixelDataType = 6'($urandom);
      bllpLowPower = 1'($urandom); bllpUseNull = 1'($urandom);
      runScenario(2, 40, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule